// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-pin general-purpose I/O port reached over a plain 32-bit register bus. Its data register does not sit at one address: it answers across a 256-word window, and bits [9:2] of the access address act as a per-bit mask. A write changes only the data bits whose mask bit is set. A read returns zero in every bit whose mask bit is clear. Two independent software agents can therefore own separate pins and update them with a single store each, with no read-modify-write sequence and no race between them.

A direction byte, at its own word offset above the data window, decides for each pin whether it drives or listens. Each pin's output enable is its direction bit, and each pin's output value is its latched data bit. The latch keeps what was written even while the pin is an input. Pin inputs pass through a two-flop synchronizer before they can be read. Read data is registered. It is valid one clock after the read strobe and holds until the next read.

Top module: `maskgpio_port`

## Requirements
- R1: After synchronous reset, pin_out, pin_oe and bus_rdata are all zero. Every pin starts as an input.
- R2: A write whose address falls in the data window (bus_addr[11:10] == 0) updates data bit i only when bus_addr[i+2] is 1. Every other data bit keeps its value. A write with mask 0x00 changes nothing.
- R3: Write data bits 31:8 have no effect on the port. Reading the data register back with a full mask returns 0 in bits 31:8.
- R4: The direction register is at word offset 0x400. Bit i = 1 makes pin i an output. A write loads all 8 bits without masking. pin_oe always equals the direction register, and a read of 0x400 returns it in bits 7:0.
- R5: pin_out equals the data latch. The latch is written whatever the direction is. A pin switched to output drives the value already held, from the next clock.
- R6: A data-window read returns 0 in every bit i whose mask bit bus_addr[i+2] is 0.
- R7: For an unmasked bit, a data-window read returns the latch bit if the pin is an output. If the pin is an input, it returns the synchronized pin level.
- R8: Pin inputs pass through two flops. With bus_rd held high, a pin change made before rising edge k shows in bus_rdata after edge k+2, and not after edge k+1.
- R9: bus_rdata is registered. It updates only on a clock with bus_rd high and holds otherwise. Bits 31:8 are always 0. Accesses outside the data window and the direction offset read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The bench stores through partial masks, including an empty mask and a single-bit mask. A design that ignored the mask, or that cleared the unselected bits, would corrupt the neighbouring pins. Reads use complementary masks over a mixed direction setting. This exposes a design that leaks masked bits, or that returns the latch for input pins or the pin level for output pins. The bench also writes the latch while the pins are inputs and then flips the direction, to catch a latch that only loads on output pins. A held read strobe is used to count the synchronizer stages exactly, so one stage too few or too many shows up as an early or late value.

// File: rtl/maskgpio_pkg.sv
package maskgpio_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } sel_e;
endpackage

// File: rtl/maskgpio_decode.sv
module maskgpio_decode
  import maskgpio_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int ADDR_W     = 12,
  parameter int DIR_OFFSET = 'h400
) (
  input  logic [ADDR_W-1:0]   addr,
  output sel_e                sel,
  output logic [NUM_PINS-1:0] mask
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int WIN_LO = NUM_PINS + 2;
  localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(DIR_OFFSET >> 2);

  logic in_window;
  logic is_dir;
  logic unused_byte_lanes;

  assign unused_byte_lanes = ^addr[1:0];
  assign mask      = addr[NUM_PINS+1:2];
  assign in_window = (addr[ADDR_W-1:WIN_LO] == '0);
  assign is_dir    = (addr[ADDR_W-1:2] == DIR_WORD);

  always_comb begin
    if (in_window)   sel = SEL_DATA;
    else if (is_dir) sel = SEL_DIR;
    else             sel = SEL_NONE;
  end
endmodule

// File: rtl/maskgpio_sync.sv
module maskgpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/maskgpio_regs.sv
module maskgpio_regs #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                data_we,
  input  logic                dir_we,
  input  logic [NUM_PINS-1:0] mask,
  input  logic [NUM_PINS-1:0] wval,
  output logic [NUM_PINS-1:0] latch_q,
  output logic [NUM_PINS-1:0] dir_q
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                    latch_q[i] <= 1'b0;
      else if (data_we && mask[i]) latch_q[i] <= wval[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (dir_we) dir_q <= wval;
  end
endmodule

// File: rtl/maskgpio_rdpath.sv
module maskgpio_rdpath
  import maskgpio_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd,
  input  sel_e                sel,
  input  logic [NUM_PINS-1:0] mask,
  input  logic [NUM_PINS-1:0] latch_q,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] pins_sync,
  output logic [DATA_W-1:0]   rdata
);
  localparam int PAD_W = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] live;
  logic [NUM_PINS-1:0] pick;

  assign live = (dir_q & latch_q) | (~dir_q & pins_sync);

  always_comb begin
    unique case (sel)
      SEL_DATA: pick = live & mask;
      SEL_DIR:  pick = dir_q;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= {{PAD_W{1'b0}}, pick};
  end
endmodule

// File: rtl/maskgpio_port.sv
module maskgpio_port
  import maskgpio_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DIR_OFFSET  = 'h400
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  sel_e                sel;
  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] latch_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] pins_sync;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

  maskgpio_decode #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)
  ) u_decode (
    .addr(bus_addr), .sel(sel), .mask(mask)
  );

  maskgpio_sync #(
    .WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
  );

  maskgpio_regs #(
    .NUM_PINS(NUM_PINS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .data_we(bus_wr && (sel == SEL_DATA)),
    .dir_we(bus_wr && (sel == SEL_DIR)),
    .mask(mask),
    .wval(bus_wdata[NUM_PINS-1:0]),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  maskgpio_rdpath #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W)
  ) u_rdpath (
    .clk(clk), .rst(rst), .rd(bus_rd), .sel(sel), .mask(mask),
    .latch_q(latch_q), .dir_q(dir_q), .pins_sync(pins_sync),
    .rdata(bus_rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/maskgpio_port_chk.sv
module maskgpio_port_chk #(
  parameter int NUM_PINS   = 8,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int DIR_OFFSET = 'h400
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  logic [NUM_PINS-1:0] msk;
  logic                win;
  logic                dirhit;
  logic                unused_chk;

  assign msk    = bus_addr[NUM_PINS+1:2];
  assign win    = (bus_addr[ADDR_W-1:NUM_PINS+2] == '0);
  assign dirhit = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(DIR_OFFSET >> 2));
  assign unused_chk = ^{bus_addr[1:0], bus_wdata[DATA_W-1:NUM_PINS], pin_in};

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0)); // R1

  AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && win) |=>
      pin_out == (($past(pin_out) & ~$past(msk)) | ($past(bus_wdata[NUM_PINS-1:0]) & $past(msk)))); // R2

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dirhit) |=> pin_oe == $past(bus_wdata[NUM_PINS-1:0])); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> ($stable(pin_out) && $stable(pin_oe))); // R9

  AST_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && win) |=> ((bus_rdata[NUM_PINS-1:0] & ~$past(msk)) == '0)); // R6

  AST_READ_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && win) |=>
      ((bus_rdata[NUM_PINS-1:0] & $past(pin_oe)) == ($past(pin_out) & $past(pin_oe) & $past(msk)))); // R7

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NUM_PINS] == '0); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R9
endmodule

bind maskgpio_port maskgpio_port_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIR_OFFSET(DIR_OFFSET)
) u_chk (.*);

// File: tb/maskgpio_port_bench.sv
module maskgpio_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maskgpio_port u_maskgpio_port (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rd(rd), .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [11:0] maddr(logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 pin_oe",  32'(pin_oe),  32'h0);
    check("R1 rdata",   rdata,        32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] d;
    bus_write(12'h400, 32'hFFFF_FF0F);
    check("R4 pin_oe", 32'(pin_oe), 32'h0F);
    bus_read(12'h400, d);
    check("R4 dir readback", d, 32'h0000_000F);
  endtask

  task automatic t_masked_write();
    logic [31:0] d;
    bus_write(12'h400, 32'hFF);
    bus_write(maddr(8'hFF), 32'hA5);
    check("R2 full mask", 32'(pin_out), 32'hA5);
    bus_write(maddr(8'h01), 32'h00);
    check("R2 single bit clear", 32'(pin_out), 32'hA4);
    bus_write(maddr(8'h40), 32'hFF);
    check("R2 single bit set", 32'(pin_out), 32'hE4);
    bus_write(maddr(8'h00), 32'hFF);
    check("R2 empty mask", 32'(pin_out), 32'hE4);
    bus_write(maddr(8'hFF), 32'hFFFF_FF00);
    check("R3 upper write bits", 32'(pin_out), 32'h00);
    bus_read(maddr(8'hFF), d);
    check("R3 upper read bits", d, 32'h0);
  endtask

  task automatic t_masked_read();
    logic [31:0] d;
    bus_write(maddr(8'hFF), 32'h3C);
    bus_read(maddr(8'h0F), d);
    check("R6 low mask", d, 32'h0C);
    bus_read(maddr(8'hF0), d);
    check("R6 high mask", d, 32'h30);
  endtask

  task automatic t_mixed_source();
    logic [31:0] d;
    @(negedge clk); pin_in = 8'h96;
    bus_write(12'h400, 32'h00);
    bus_read(maddr(8'hFF), d);
    check("R7 all inputs", d, 32'h96);
    bus_write(12'h400, 32'hF0);
    bus_read(maddr(8'hFF), d);
    check("R7 mixed", d, 32'h36);
  endtask

  task automatic t_hold_latch();
    logic [31:0] d;
    bus_write(12'h400, 32'h00);
    bus_write(maddr(8'hFF), 32'h5A);
    check("R5 latch while input", 32'(pin_out), 32'h5A);
    check("R5 still input", 32'(pin_oe), 32'h00);
    bus_write(12'h400, 32'hFF);
    check("R5 drives held value", 32'(pin_out), 32'h5A);
    bus_read(maddr(8'hFF), d);
    check("R5 readback", d, 32'h5A);
  endtask

  task automatic t_sync_latency();
    bus_write(12'h400, 32'h00);
    @(negedge clk); pin_in = 8'h00;
    repeat (3) @(negedge clk);
    addr = maddr(8'hFF); rd = 1'b1;
    @(negedge clk); pin_in = 8'hFF;
    @(negedge clk); check("R8 after edge k", rdata, 32'h00);
    @(negedge clk); check("R8 after edge k+1", rdata, 32'h00);
    @(negedge clk); check("R8 after edge k+2", rdata, 32'hFF);
    rd = 1'b0;
  endtask

  task automatic t_hold_and_unmapped();
    logic [31:0] d;
    bus_read(maddr(8'hFF), d);
    check("R9 read", d, 32'hFF);
    @(negedge clk); pin_in = 8'h11;
    repeat (4) @(negedge clk);
    check("R9 rdata holds", rdata, 32'hFF);
    bus_write(12'h400, 32'hC3);
    bus_write(12'h800, 32'hFF);
    check("R9 unmapped write oe", 32'(pin_oe), 32'hC3);
    check("R9 unmapped write out", 32'(pin_out), 32'h5A);
    bus_read(12'h800, d);
    check("R9 unmapped read", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_direction();
    t_masked_write();
    t_masked_read();
    t_mixed_source();
    t_hold_latch();
    t_sync_latency();
    t_hold_and_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule